// File: doc/BRIEF.md
# Bit-Masked General-Purpose I/O Port

This block is a small I/O port with one pad per line (eight by default) behind a simple memory-mapped register bus that carries byte-wide data. Software controls two pieces of state. The first is a direction register that chooses, line by line, whether the block drives the pad. The second is an output value register that holds the level driven on lines set as outputs. Pad inputs pass through a multi-flop synchronizer before anything reads them.

The data value is reached through a window of word addresses, not a single address. Address bits [9:2] act as a per-line select mask for both reads and writes. A write changes only the selected lines. A read returns zero on the lines that are not selected. Software can therefore set or test one line, or any group of lines, in a single bus access without a read-modify-write. A data write reaches only lines that are outputs at that moment, so a level written before a line is turned to output is lost and has to be written again. Bus reads are combinational from the address. Writes take effect at the rising clock edge on which the write enable is sampled high.

Top module: `maskgpio_port`

## Requirements
- R1: After reset is asserted (rst_n low), pad_oe and pad_out are all zero, the direction register reads 0x00, and a full-mask data read returns 0x00.
- R2: A write in the data window (bus_addr[11:10] = 2'b00) loads bus_wdata[n] into the output value of line n only when bus_addr[n+2] is 1 and line n is an output. All other output bits keep their value.
- R3: A data write to a line that is an input leaves that line's stored output value unchanged. When the line is later turned to output, it drives the value that was stored before, until it is written again.
- R4: A read in the data window returns 0 on every line n whose mask bit bus_addr[n+2] is 0.
- R5: A selected line that is an input reads the pad level through a two-flop synchronizer. A pad change becomes readable after the second rising edge, and not after the first.
- R6: A selected line that is an output reads its stored output value, whatever the pad level is.
- R7: The direction register is at word address 0x400 (bus_addr[11:2] = 0x100). Bit n = 1 makes line n an output. pad_oe equals the register. A read during the cycle that writes it returns the old value.
- R8: pad_out[n] carries the stored output value of line n when line n is an output, and is 0 when line n is an input.
- R9: Addresses outside the data window and the direction word read as 0x00, and writes to them change no state.
- R10: bus_addr[1:0] has no effect on decode or on the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write enable, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
Two functions can fall in the same cycle. One is a register update at the clock edge. The other is the combinational readback, which reads the very register being written, or a line whose source is switching between pad and output value. The bench writes the direction register while addressing it, samples bus_rdata before the edge and expects the old value, then reads back after the edge and expects the new value. It also flips direction while the pad level differs from the stored output, and judges the full-mask data read on each side of the edge. It times a pad change across the synchronizer edge by edge, so it can tell a one-flop path from a two-flop one.

// File: rtl/maskgpio_pkg.sv
package maskgpio_pkg;

   // Which register an access selects
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_DIR  = 2'd2
   } reg_sel_e;

endpackage

// File: rtl/maskgpio_decode.sv
module maskgpio_decode
   import maskgpio_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int NUM_LINES  = 8,
   parameter int DIR_OFFSET = 'h400
) (
   input  logic [ADDR_W-1:0]    addr,
   output reg_sel_e             sel,
   output logic [NUM_LINES-1:0] mask
);

   localparam int MASK_LO = 2;
   localparam int MASK_HI = NUM_LINES + 1;
   localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

   logic win_hit;
   logic dir_hit;
   logic unused_byte_lanes;

   // byte-lane bits carry no meaning for this word-organised block
   assign unused_byte_lanes = ^addr[MASK_LO-1:0];

   assign win_hit = (addr[ADDR_W-1:MASK_HI+1] == '0);
   assign dir_hit = (addr[ADDR_W-1:MASK_LO] == DIR_ADDR[ADDR_W-1:MASK_LO]);
   assign mask    = addr[MASK_HI:MASK_LO];

   always_comb begin
      if (win_hit)      sel = SEL_DATA;
      else if (dir_hit) sel = SEL_DIR;
      else              sel = SEL_NONE;
   end

endmodule

// File: rtl/maskgpio_sync.sv
module maskgpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/maskgpio_regs.sv
module maskgpio_regs #(
   parameter int NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dir_we,
   input  logic                 data_we,
   input  logic [NUM_LINES-1:0] mask,
   input  logic [NUM_LINES-1:0] wdata,
   output logic [NUM_LINES-1:0] dir_q,
   output logic [NUM_LINES-1:0] out_q
);

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      logic out_upd;

      // the stored level moves only for a selected line that already drives
      assign out_upd = data_we & mask[n] & dir_q[n];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      dir_q[n] <= 1'b0;
         else if (dir_we) dir_q[n] <= wdata[n];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       out_q[n] <= 1'b0;
         else if (out_upd) out_q[n] <= wdata[n];
      end
   end

endmodule

// File: rtl/maskgpio_port.sv
module maskgpio_port
   import maskgpio_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int BUS_W       = 8,
   parameter int NUM_LINES   = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DIR_OFFSET  = 'h400
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   input  logic [NUM_LINES-1:0] pad_in,
   output logic [NUM_LINES-1:0] pad_out,
   output logic [NUM_LINES-1:0] pad_oe
);

   localparam int WIN_BYTES = 1 << (NUM_LINES + 2);

   // elaboration-time parameter checks
   if (NUM_LINES < 1 || NUM_LINES > BUS_W) begin : g_bad_lines
      $error("maskgpio_port: NUM_LINES must be in 1..BUS_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("maskgpio_port: SYNC_STAGES must be at least 2");
   end
   if (NUM_LINES + 3 > ADDR_W) begin : g_bad_addr
      $error("maskgpio_port: ADDR_W too narrow for the mask window");
   end
   if (DIR_OFFSET < WIN_BYTES || DIR_OFFSET >= (1 << ADDR_W) || (DIR_OFFSET % 4) != 0) begin : g_bad_dir
      $error("maskgpio_port: DIR_OFFSET must be word aligned, above the window, inside the map");
   end

   reg_sel_e             sel;
   logic [NUM_LINES-1:0] mask;
   logic [NUM_LINES-1:0] dir_q;
   logic [NUM_LINES-1:0] out_q;
   logic [NUM_LINES-1:0] pin_sync;
   logic [NUM_LINES-1:0] line_val;
   logic [NUM_LINES-1:0] rd_lines;
   logic                 dir_we;
   logic                 data_we;

   maskgpio_decode #(
      .ADDR_W     (ADDR_W),
      .NUM_LINES  (NUM_LINES),
      .DIR_OFFSET (DIR_OFFSET)
   ) u_decode (
      .addr (bus_addr),
      .sel  (sel),
      .mask (mask)
   );

   assign dir_we  = bus_wr & (sel == SEL_DIR);
   assign data_we = bus_wr & (sel == SEL_DATA);

   maskgpio_regs #(
      .NUM_LINES (NUM_LINES)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .dir_we  (dir_we),
      .data_we (data_we),
      .mask    (mask),
      .wdata   (bus_wdata[NUM_LINES-1:0]),
      .dir_q   (dir_q),
      .out_q   (out_q)
   );

   maskgpio_sync #(
      .WIDTH  (NUM_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (pin_sync)
   );

   // per-line read source: own level when driving, pad level otherwise
   for (genvar n = 0; n < NUM_LINES; n++) begin : g_src
      assign line_val[n] = dir_q[n] ? out_q[n] : pin_sync[n];
   end

   always_comb begin
      unique case (sel)
         SEL_DATA: rd_lines = line_val & mask;
         SEL_DIR:  rd_lines = dir_q;
         default:  rd_lines = '0;
      endcase
   end

   if (BUS_W > NUM_LINES) begin : g_pad_rd
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[BUS_W-1:NUM_LINES];
      assign bus_rdata = {{(BUS_W-NUM_LINES){1'b0}}, rd_lines};
   end else begin : g_full_rd
      assign bus_rdata = rd_lines;
   end

   assign pad_oe  = dir_q;
   assign pad_out = out_q & dir_q;

endmodule

// File: rtl/maskgpio_chk.sv
module maskgpio_chk #(
   parameter int ADDR_W     = 12,
   parameter int BUS_W      = 8,
   parameter int NUM_LINES  = 8,
   parameter int DIR_OFFSET = 'h400
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_wr,
   input logic [BUS_W-1:0]     bus_wdata,
   input logic [BUS_W-1:0]     bus_rdata,
   input logic [NUM_LINES-1:0] pad_in,
   input logic [NUM_LINES-1:0] pad_out,
   input logic [NUM_LINES-1:0] pad_oe
);

   localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_OFFSET);

   logic                 in_win;
   logic                 at_dir;
   logic [NUM_LINES-1:0] sel_m;
   logic [1:0]           age;
   logic                 unused_chk;

   assign unused_chk = ^bus_addr[1:0];
   assign in_win = (bus_addr[ADDR_W-1:NUM_LINES+2] == '0);
   assign at_dir = (bus_addr[ADDR_W-1:2] == DIR_A[ADDR_W-1:2]);
   assign sel_m  = bus_addr[NUM_LINES+1:2];

   // edges seen since reset, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R7: a direction write shows up on pad_oe after the edge
   p_dir_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_dir) |=> (pad_oe == $past(bus_wdata[NUM_LINES-1:0])));

   // R2 / R3: a data write touches only selected lines that are outputs
   p_masked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && in_win) |=>
      (((pad_out ^ $past(pad_out)) & ~($past(sel_m) & $past(pad_oe))) == '0));

   // R4: unselected lines read zero
   p_masked_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_win |-> ((bus_rdata[NUM_LINES-1:0] & ~sel_m) == '0));

   // R5: selected inputs show the pad level from two edges back
   p_sync_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && in_win) |->
      (((bus_rdata[NUM_LINES-1:0] ^ $past(pad_in, 2)) & sel_m & ~pad_oe) == '0));

   // R8: no level is presented on an undriven pad
   p_undriven_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & ~pad_oe) == '0));

   // R9: holes in the map read zero
   p_hole_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_win && !at_dir) |-> (bus_rdata == '0));

   // R9: writes to holes leave direction and outputs alone
   p_hole_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !in_win && !at_dir) |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

bind maskgpio_port maskgpio_chk #(
   .ADDR_W     (ADDR_W),
   .BUS_W      (BUS_W),
   .NUM_LINES  (NUM_LINES),
   .DIR_OFFSET (DIR_OFFSET)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_in    (pad_in),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe)
);

// File: tb/sim_maskgpio_port.sv
`timescale 1ns/1ps
module sim_maskgpio_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  pad_in = '0;
   logic [7:0]  pad_out;
   logic [7:0]  pad_oe;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   maskgpio_port u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe)
   );

   typedef struct packed {
      logic [23:0] tag;
      logic        wen;
      logic [11:0] waddr;
      logic [7:0]  wdata;
      logic [7:0]  pad;
      logic [11:0] raddr;
      logic [7:0]  exp_rd;
      logic [7:0]  exp_out;
      logic [7:0]  exp_oe;
   } row_t;

   localparam int NROWS = 11;
   localparam row_t TBL [NROWS] = '{
      '{"R7 ", 1'b1, 12'h400, 8'h0F, 8'hA5, 12'h3FC, 8'hA0, 8'h00, 8'h0F},
      '{"R2 ", 1'b1, 12'h3FC, 8'hFF, 8'hA5, 12'h3FC, 8'hAF, 8'h0F, 8'h0F},
      '{"R2 ", 1'b1, 12'h008, 8'h00, 8'hA5, 12'h3FC, 8'hAD, 8'h0D, 8'h0F},
      '{"R3 ", 1'b1, 12'h300, 8'hFF, 8'h3C, 12'h3FC, 8'h3D, 8'h0D, 8'h0F},
      '{"R3 ", 1'b1, 12'h400, 8'hFF, 8'h3C, 12'h3FC, 8'h0D, 8'h0D, 8'hFF},
      '{"R10", 1'b1, 12'h300, 8'h80, 8'h3C, 12'h201, 8'h80, 8'h8D, 8'hFF},
      '{"R9 ", 1'b1, 12'h404, 8'h00, 8'hFF, 12'h404, 8'h00, 8'h8D, 8'hFF},
      '{"R9 ", 1'b1, 12'h800, 8'h00, 8'hFF, 12'h400, 8'hFF, 8'h8D, 8'hFF},
      '{"R10", 1'b1, 12'h402, 8'h00, 8'hFF, 12'h3FC, 8'hFF, 8'h00, 8'h00},
      '{"R4 ", 1'b0, 12'h000, 8'h00, 8'h5A, 12'h028, 8'h0A, 8'h00, 8'h00},
      '{"R6 ", 1'b1, 12'h400, 8'hF0, 8'h5A, 12'h3FC, 8'h8A, 8'h80, 8'hF0}
   };

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   initial begin
      logic [7:0] rd;

      // R1: reset state
      pad_in = 8'hFF;
      repeat (3) @(negedge clk);
      check("R1", "pad_oe in reset", pad_oe, 8'h00);
      check("R1", "pad_out in reset", pad_out, 8'h00);
      bus_read(12'h400, rd);
      check("R1", "dir read in reset", rd, 8'h00);
      bus_read(12'h3FC, rd);
      check("R1", "sync cleared in reset", rd, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NROWS; i++) begin
         @(negedge clk);
         pad_in = TBL[i].pad;
         repeat (3) @(posedge clk);
         if (TBL[i].wen) bus_write(TBL[i].waddr, TBL[i].wdata);
         bus_read(TBL[i].raddr, rd);
         check(string'(TBL[i].tag), $sformatf("row %0d rdata", i), rd, TBL[i].exp_rd);
         check(string'(TBL[i].tag), $sformatf("row %0d pad_out", i), pad_out, TBL[i].exp_out);
         check(string'(TBL[i].tag), $sformatf("row %0d pad_oe", i), pad_oe, TBL[i].exp_oe);
      end

      // R5: synchronizer depth, low nibble inputs (dir=F0, out=8D)
      @(negedge clk);
      bus_addr = 12'h3FC;
      pad_in   = 8'h05;
      @(negedge clk);
      #1 check("R5", "after one edge", bus_rdata, 8'h8A);
      @(negedge clk);
      #1 check("R5", "after two edges", bus_rdata, 8'h85);

      // R7: same-cycle direction write and readback
      @(negedge clk);
      bus_addr  = 12'h400;
      bus_wdata = 8'h0F;
      bus_wr    = 1'b1;
      #1 check("R7", "read during dir write", bus_rdata, 8'hF0);
      @(negedge clk);
      bus_wr = 1'b0;
      #1 check("R7", "read after dir write", bus_rdata, 8'h0F);
      bus_read(12'h3FC, rd);
      check("R6", "source swap after dir flip", rd, 8'h0D);
      check("R8", "pad_out after dir flip", pad_out, 8'h0D);

      // R1: reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1 check("R1", "pad_oe after rerun reset", pad_oe, 8'h00);
      check("R1", "pad_out after rerun reset", pad_out, 8'h00);
      bus_read(12'h3FC, rd);
      check("R1", "data after rerun reset", rd, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule